// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit-side DMA engine of an Ethernet controller. Software builds a ring of 8-byte descriptors in memory, each naming one fragment of a frame. It hands a descriptor to the hardware by setting its ready flag, then pulses a doorbell. The walker reads each ready descriptor in turn and gathers the fragment bytes through a 32-bit request/response memory port. It streams those bytes on a byte-wide valid/ready interface and marks the final byte of a frame with `tx_last`. It then writes the descriptor back with the ready flag cleared and pulses event bits for the interrupt logic.

The current-descriptor pointer moves forward by 8 after each descriptor. It returns to the ring-start register when a descriptor carries the wrap flag. The walk stops at the first descriptor that is not ready, and the pointer is left on that descriptor so the next doorbell resumes there. The state machine has six states. IDLE waits for a doorbell or a remembered one. RD_HEAD reads word 0: ready goes to RD_BUF, not ready goes back to IDLE. RD_BUF reads the buffer address and clamps the length: a zero clamped length goes to WRBACK, any other length goes to FETCH. FETCH reads a data word and moves to SEND. SEND emits one byte per accepted transfer. It returns to FETCH at a word boundary and moves to WRBACK after the last byte. WRBACK writes word 0 back and returns to RD_HEAD.

Top module: `txd_ring_walker`

## Requirements
- R1: A descriptor is two words. Word 0 is {flags[15:0], length[15:0]} with ready at word bit 31, wrap at word bit 29 and last at word bit 27. Word 1 is the byte address of the buffer. The walker emits the clamped length in bytes, in ascending address order. The byte at address a sits in bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a with its low two bits cleared.
- R2: After a descriptor is written back, the pointer advances by 8. If that descriptor's wrap flag is set, the pointer reloads from the ring-start register instead.
- R3: The walk ends at the first descriptor whose ready flag is clear. `busy` falls and `cur_ptr` holds that descriptor's address.
- R4: Each consumed descriptor's word 0 is written back to its own address with only the ready bit cleared. The other flags and the original length are kept.
- R5: `evt_buf` pulses once per consumed descriptor, in the cycle its write-back is accepted. `evt_frame` pulses in that same cycle when the descriptor has the last flag.
- R6: `tx_last` is high only on the final emitted byte of a descriptor that has the last flag.
- R7: Let MAX_FRAME be the limit and acc the frame bytes already taken. If acc plus a fragment's length would exceed MAX_FRAME, the fragment is cut to MAX_FRAME minus acc, and `evt_babble` pulses with that descriptor's write-back. A fragment cut to zero emits no bytes.
- R8: A doorbell has no effect while `ctrl_en` is low: no memory request is issued and `busy` stays low.
- R9: A write to the ring-start register clears the low 2 bits of the written value. It loads the result into both the ring-start register and `cur_ptr`.
- R10: A doorbell that arrives while a walk is running is remembered. When the walk ends, the descriptor at the pointer is read again.
- R11: While a byte is offered and `tx_ready` is low, no memory request is issued, and the byte and its last marker stay unchanged.
- R12: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`.
- R13: After reset the walker is idle, with `cur_ptr` at 0 and no request, stream byte or event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable level; gates the doorbell |
| doorbell | input | 1 | One-cycle pulse: descriptors are ready |
| base_we | input | 1 | Write strobe for the ring-start register |
| base_wdata | input | ADDR_W | Ring-start value to write |
| busy | output | 1 | High while a walk is in progress |
| cur_ptr | output | ADDR_W | Current descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink ready |
| evt_buf | output | 1 | Descriptor consumed event |
| evt_frame | output | 1 | Frame finished event |
| evt_babble | output | 1 | Over-long frame truncated event |

## Verification
The hardest case to reach is a doorbell that lands mid-walk. Its only trace is a second read of the terminating descriptor. The bench throttles `tx_ready` so the walk stays busy, rings again while it runs, and counts memory reads of the terminator's address. A fragment truncated all the way to zero is also hard to reach. It needs a frame that fills the limit exactly before its last fragment, so the bench shrinks MAX_FRAME to 64 and builds that frame directly. Random rings with unaligned buffers, random wrap and random memory and stream stalls cover the remaining orderings.

// File: rtl/txw_pkg.sv
package txw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HEAD,
        ST_RD_BUF,
        ST_FETCH,
        ST_SEND,
        ST_WRBACK
    } txw_state_e;

    // flag positions inside the 16-bit flag half of descriptor word 0
    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;

    localparam int DESC_BYTES = 8;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 32;

endpackage

// File: rtl/txw_len_clamp.sv
module txw_len_clamp #(
    parameter int MAX_FRAME = 2048,
    parameter int LEN_W     = 16,
    parameter int FL_W      = 12
) (
    input  logic [FL_W-1:0]  acc,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] eff_len,
    output logic             over
);
    logic [31:0] room;

    always_comb begin
        room    = 32'(MAX_FRAME) - 32'(acc);
        over    = 32'(req_len) > room;
        eff_len = over ? LEN_W'(room) : req_len;
    end
endmodule

// File: rtl/txw_byte_unpack.sv
module txw_byte_unpack #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / 8,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [SEL_W-1:0]  sel,
    output logic [7:0]        byte_out
);
    logic [WORD_W-1:0] word_q;
    logic [7:0]        lanes [LANES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_q[8*g +: 8];
    end

    assign byte_out = lanes[sel];
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
    import txw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              doorbell,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              evt_buf,
    output logic              evt_frame,
    output logic              evt_babble
);
    localparam int FL_W  = $clog2(MAX_FRAME + 1);
    localparam int SEL_W = $clog2(WORD_W / 8);

    txw_state_e state_q, state_d;

    logic [ADDR_W-1:0] ptr_q, base_q, baddr_q;
    logic [HALF_W-1:0] flags_q, len_q, left_q;
    logic [FL_W-1:0]   acc_q;
    logic              babble_q, pend_q;

    logic [HALF_W-1:0] eff_len;
    logic              over;
    logic              start;
    logic              wb_done;
    logic [HALF_W-1:0] wb_flags;

    txw_len_clamp #(
        .MAX_FRAME (MAX_FRAME),
        .LEN_W     (HALF_W),
        .FL_W      (FL_W)
    ) u_clamp (
        .acc     (acc_q),
        .req_len (len_q),
        .eff_len (eff_len),
        .over    (over)
    );

    txw_byte_unpack #(
        .WORD_W (WORD_W)
    ) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_FETCH && mem_ack),
        .word_in  (mem_rdata),
        .sel      (baddr_q[SEL_W-1:0]),
        .byte_out (tx_data)
    );

    assign start   = (doorbell && ctrl_en) || pend_q;
    assign wb_done = (state_q == ST_WRBACK) && mem_ack;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_RD_HEAD;
            ST_RD_HEAD: if (mem_ack) begin
                            state_d = mem_rdata[HALF_W + FLAG_READY] ? ST_RD_BUF : ST_IDLE;
                        end
            ST_RD_BUF:  if (mem_ack) begin
                            state_d = (eff_len == '0) ? ST_WRBACK : ST_FETCH;
                        end
            ST_FETCH:   if (mem_ack) state_d = ST_SEND;
            ST_SEND:    if (tx_ready) begin
                            if (left_q == HALF_W'(1))
                                state_d = ST_WRBACK;
                            else if (&baddr_q[SEL_W-1:0])
                                state_d = ST_FETCH;
                        end
            ST_WRBACK:  if (mem_ack) state_d = ST_RD_HEAD;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            base_q   <= '0;
            baddr_q  <= '0;
            flags_q  <= '0;
            len_q    <= '0;
            left_q   <= '0;
            acc_q    <= '0;
            babble_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            pend_q <= (state_q != ST_IDLE) && (pend_q || (doorbell && ctrl_en));

            if (state_q == ST_RD_HEAD && mem_ack) begin
                flags_q <= mem_rdata[WORD_W-1:HALF_W];
                len_q   <= mem_rdata[HALF_W-1:0];
            end

            if (state_q == ST_RD_BUF && mem_ack) begin
                baddr_q  <= mem_rdata[ADDR_W-1:0];
                left_q   <= eff_len;
                babble_q <= over;
                acc_q    <= acc_q + FL_W'(eff_len);
            end

            if (state_q == ST_SEND && tx_ready) begin
                baddr_q <= baddr_q + ADDR_W'(1);
                left_q  <= left_q - HALF_W'(1);
            end

            if (wb_done && flags_q[FLAG_LAST]) begin
                acc_q <= '0;
            end

            if (base_we) begin
                base_q <= base_wdata & ~ADDR_W'(3);
                ptr_q  <= base_wdata & ~ADDR_W'(3);
            end else if (wb_done) begin
                ptr_q <= flags_q[FLAG_WRAP] ? base_q : ptr_q + ADDR_W'(DESC_BYTES);
            end
        end
    end

    // outputs
    always_comb begin
        wb_flags             = flags_q;
        wb_flags[FLAG_READY] = 1'b0;

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_RD_HEAD: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q;
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + ADDR_W'(4);
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {baddr_q[ADDR_W-1:SEL_W], SEL_W'(0)};
            end
            ST_WRBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = {wb_flags, len_q};
            end
            default: ;
        endcase

        tx_valid   = (state_q == ST_SEND);
        tx_last    = tx_valid && flags_q[FLAG_LAST] && (left_q == HALF_W'(1));
        evt_buf    = wb_done;
        evt_frame  = wb_done && flags_q[FLAG_LAST];
        evt_babble = wb_done && babble_q;
        busy       = (state_q != ST_IDLE);
        cur_ptr    = ptr_q;
    end
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready,
    input logic              evt_buf,
    input logic              evt_frame,
    input logic              evt_babble
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    stall_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |-> !mem_req);

    // R11
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    // R5
    buf_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf |-> (mem_req && mem_we && mem_ack));

    // R5
    frame_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |-> evt_buf);

    // R7
    babble_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_babble |-> evt_buf);

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .evt_buf    (evt_buf),
    .evt_frame  (evt_frame),
    .evt_babble (evt_babble)
);

// File: tb/txd_ring_walker_tb.sv
module txd_ring_walker_tb;
    localparam int MAXF = 64;
    localparam logic [15:0] F_RDY  = 16'h8000;
    localparam logic [15:0] F_WRAP = 16'h2000;
    localparam logic [15:0] F_LAST = 16'h0800;

    logic        clk = 1'b0;
    logic        rst_n, ctrl_en, doorbell, base_we;
    logic [31:0] base_wdata;
    logic        busy;
    logic [31:0] cur_ptr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        evt_buf, evt_frame, evt_babble;

    always #10 clk = ~clk;

    txd_ring_walker #(.ADDR_W(32), .MAX_FRAME(MAXF)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .doorbell(doorbell),
        .base_we(base_we), .base_wdata(base_wdata), .busy(busy), .cur_ptr(cur_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .evt_buf(evt_buf), .evt_frame(evt_frame),
        .evt_babble(evt_babble)
    );

    logic [31:0] mem [0:1023];
    int          rd_count [0:1023];
    logic [8:0]  exp_q [$];
    int n_chk = 0, n_err = 0;
    int n_buf, n_frame, n_bab, req_seen;
    int exp_buf, exp_frame, exp_bab, m_acc = 0;
    logic [31:0] exp_ptr, ring_base;
    int ack_pct = 100, rdy_pct = 100;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    // memory responder and stream sink
    initial begin
        mem_ack = 1'b0; mem_rdata = '0; tx_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_req && ($urandom % 100 < ack_pct)) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    rd_count[mem_addr[11:2]]++;
                end
            end else begin
                mem_ack = 1'b0;
            end
            tx_ready = ($urandom % 100 < rdy_pct);
            #1;
            if (mem_req) req_seen++;
            if (evt_buf) n_buf++;
            if (evt_frame) n_frame++;
            if (evt_babble) n_bab++;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) chk("R1 extra byte", {tx_last, tx_data}, 9'h1ff);
                else chk("R1 R6 stream byte", {tx_last, tx_data}, exp_q.pop_front());
            end
        end
    end

    // reference walk over the ring as it stands before the run
    task automatic model_walk();
        bit cleared [int];
        int p = int'(cur_ptr);
        exp_buf = 0; exp_frame = 0; exp_bab = 0;
        for (int k = 0; k < 64; k++) begin
            logic [31:0] w0 = mem[p >> 2];
            int len, eff, ba, room;
            if (cleared.exists(p)) w0[31] = 1'b0;
            if (!w0[31]) break;
            len = int'(w0[15:0]);
            ba = int'(mem[(p + 4) >> 2]);
            room = MAXF - m_acc;
            eff = len;
            if (len > room) begin eff = room; exp_bab++; end
            for (int i = 0; i < eff; i++)
                exp_q.push_back({w0[27] && (i == eff - 1), mbyte(ba + i)});
            m_acc += eff;
            exp_buf++;
            if (w0[27]) begin exp_frame++; m_acc = 0; end
            cleared[p] = 1'b1;
            p = w0[29] ? int'(ring_base) : p + 8;
        end
        exp_ptr = 32'(p);
    endtask

    task automatic put_desc(int a, logic [15:0] fl, int len, int ba);
        mem[a >> 2] = {fl, 16'(len)};
        mem[(a + 4) >> 2] = 32'(ba);
    endtask

    task automatic fill_buf(int a, int len);
        for (int i = 0; i < len; i++) mem[(a + i) >> 2][8*((a + i) % 4) +: 8] = 8'($urandom);
    endtask

    task automatic set_base(logic [31:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
        ring_base = v & ~32'h3;
    endtask

    task automatic ring();
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
    endtask

    task automatic clear_counts();
        n_buf = 0; n_frame = 0; n_bab = 0; req_seen = 0;
        for (int i = 0; i < 1024; i++) rd_count[i] = 0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int t = 0; t < 20000 && quiet < 4; t++) begin
            @(negedge clk); #2;
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic end_checks(string tag);
        chk({tag, " R1 bytes left over"}, 64'(exp_q.size()), 64'd0);
        chk({tag, " R5 buffer events"}, 64'(n_buf), 64'(exp_buf));
        chk({tag, " R5 frame events"}, 64'(n_frame), 64'(exp_frame));
        chk({tag, " R7 babble events"}, 64'(n_bab), 64'(exp_bab));
        chk({tag, " R3 final pointer"}, 64'(cur_ptr), 64'(exp_ptr));
        exp_q.delete();
    endtask

    task automatic run(string tag);
        clear_counts();
        model_walk();
        ring();
        wait_idle();
        end_checks(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R3 watchdog actual still running expected walk to end");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] orig;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ctrl_en = 1'b0; doorbell = 1'b0; base_we = 1'b0; base_wdata = '0;
        ring_base = '0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        clear_counts();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R13 reset state
        chk("R13 busy", 64'(busy), 64'd0);
        chk("R13 pointer", 64'(cur_ptr), 64'd0);
        chk("R13 no stream", 64'(tx_valid), 64'd0);
        chk("R13 no request", 64'(mem_req), 64'd0);

        // R9 low bits masked
        set_base(32'h13); #2;
        chk("R9 pointer load", 64'(cur_ptr), 64'h10);

        // R8 doorbell while disabled
        set_base(32'h20);
        put_desc(32'h20, F_RDY | F_LAST, 9, 32'h401); fill_buf(32'h401, 9);
        put_desc(32'h28, 16'h0, 0, 0);
        clear_counts();
        ring();
        repeat (12) @(negedge clk); #2;
        chk("R8 busy", 64'(busy), 64'd0);
        chk("R8 requests", 64'(req_seen), 64'd0);
        chk("R8 events", 64'(n_buf), 64'd0);

        // R1 R4 single unaligned fragment
        ctrl_en = 1'b1;
        orig = mem[32'h20 >> 2];
        run("single");
        chk("R4 write-back word", 64'(mem[32'h20 >> 2]), 64'(orig & 32'h7fff_ffff));

        // two fragments, one frame
        set_base(32'h60);
        put_desc(32'h60, F_RDY, 6, 32'h500); fill_buf(32'h500, 6);
        put_desc(32'h68, F_RDY | F_LAST, 5, 32'h50b); fill_buf(32'h50b, 5);
        put_desc(32'h70, 16'h0, 0, 0);
        run("two-frag");

        // R2 wrap back to ring start
        set_base(32'h40);
        put_desc(32'h40, F_RDY, 5, 32'h540); fill_buf(32'h540, 5);
        put_desc(32'h48, F_RDY | F_LAST, 7, 32'h546); fill_buf(32'h546, 7);
        put_desc(32'h50, F_RDY | F_LAST | F_WRAP, 3, 32'h553); fill_buf(32'h553, 3);
        run("wrap");
        chk("R2 wrap pointer", 64'(cur_ptr), 64'h40);

        // R7 truncation, exact fill, zero-length cut
        set_base(32'ha0);
        put_desc(32'ha0, F_RDY, 40, 32'h600); fill_buf(32'h600, 40);
        put_desc(32'ha8, F_RDY | F_LAST, 40, 32'h630); fill_buf(32'h630, 40);
        put_desc(32'hb0, F_RDY, 64, 32'h680); fill_buf(32'h680, 64);
        put_desc(32'hb8, F_RDY | F_LAST, 10, 32'h6d0); fill_buf(32'h6d0, 10);
        put_desc(32'hc0, 16'h0, 0, 0);
        ack_pct = 70; rdy_pct = 60;
        run("babble");
        chk("R7 two babbles", 64'(n_bab), 64'd2);
        chk("R4 length kept", 64'(mem[32'ha8 >> 2]), 64'({F_LAST, 16'd40}));

        // R10 doorbell during a walk
        set_base(32'he0);
        put_desc(32'he0, F_RDY | F_LAST, 20, 32'h700); fill_buf(32'h700, 20);
        put_desc(32'he8, 16'h0, 0, 0);
        rdy_pct = 30;
        clear_counts();
        model_walk();
        ring();
        repeat (3) @(negedge clk); #2;
        chk("R10 busy at second doorbell", 64'(busy), 64'd1);
        ring();
        wait_idle();
        chk("R10 terminator reads", 64'(rd_count[32'he8 >> 2]), 64'd2);
        end_checks("pending");

        // random rings, R11 R12 backpressure
        ack_pct = 60; rdy_pct = 50;
        for (int it = 0; it < 25; it++) begin
            int b = 32'h100 + (it % 8) * 32'h40;
            int n = 1 + int'($urandom % 5);
            int bp = 32'h400 + int'($urandom % 4);
            bit wrap_end = $urandom % 2;
            set_base(32'(b));
            for (int d = 0; d < n; d++) begin
                int len = 1 + int'($urandom % 30);
                logic [15:0] fl = F_RDY;
                if (d == n - 1 || ($urandom % 100 < 30)) fl |= F_LAST;
                if (d == n - 1 && wrap_end) fl |= F_WRAP;
                put_desc(b + 8 * d, fl, len, bp);
                fill_buf(bp, len);
                bp += len + int'($urandom % 4);
            end
            put_desc(b + 8 * n, 16'h2800 & 16'($urandom), 7, 32'h400);
            run("random");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule